// File: doc/BRIEF.md
# Stereo Double-Buffered Digital Attenuator

This block is a register-controlled volume stage for a stereo PCM sample path that feeds a converter. Each channel owns an 8-bit attenuation code in half-decibel steps. Software writes codes through a small register port into per-channel staging registers. Those codes only reach the signal path when a write carries the update command, and then both channels switch together.

The switch is handled by a two-state sequencer. `ST_IDLE` means no update is waiting. An update write moves it to `ST_ARMED` (transition "arm"). The next input sample strobe copies both staged codes into the active registers and scales that same sample pair with them (transition "apply", back to `ST_IDLE`). An update write in the same cycle as that strobe re-arms the sequencer (transition "rearm"). As a result, one sample pair never mixes old and new gain.

Linear gain is derived from the attenuation depth, which is 255 minus the code. The depth is split into a right-shift count (depth / 12) and a 12-entry mantissa table indexed by depth mod 12. The scaled sample is rounded and registered at 24 bits.

Top module: `stereo_atten`

## Requirements
- R1: After reset both active and staged codes are 0xFF, `out_valid` is 0 and both outputs are 0.
- R2: Code 0x00 mutes its channel: every sample scaled with it produces output 0.
- R3: Code 0xFF is unity gain: the output equals the input sample exactly.
- R4: For a code c from 1 to 255, let d = 255 - c. The output is the input times M[d mod 12], where M[k] = round(32768 * 2^(-k/12)), arithmetically shifted right by 15 + d/12 with half-up rounding (floor of value + 0.5), kept as 24 bits.
- R5: Address 0 holds the left channel and address 1 holds the right channel. Write data bits [7:0] carry the code and bit 8 carries the update command. Writes to addresses 2 and 3 change nothing.
- R6: A write with bit 8 at 0 changes only that channel's staged code. The gain applied to samples is unchanged.
- R7: A write to either channel with bit 8 at 1 stores its code and arms an update. At the first `in_valid` in a later cycle, both staged codes become active together. A sample presented in the same cycle as the update write still uses the previous gain.
- R8: Reading address 0 or 1 returns the staged code in bits [7:0] with bit 8 always 0. Other addresses read as 0.
- R9: `out_valid` is `in_valid` delayed by one clock, and the scaled outputs appear in that cycle. The outputs hold their value while no new sample arrives.
- R10: An armed update waits any number of idle cycles for a sample. Staging writes made while it waits are included in the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 9 | Bit 8 update command, bits [7:0] code |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 9 | Staged code readback, bit 8 reads 0 |
| in_valid | input | 1 | Input sample pair strobe |
| in_left | input | 24 | Left sample, signed |
| in_right | input | 24 | Right sample, signed |
| out_valid | output | 1 | Output sample pair strobe |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |

## Verification
The bench targets an update write that lands in the same cycle as a sample. A design that applied the update early would scale that sample with the new gain. It also tests updates issued from the right address alone, where a design that transferred only the written channel would leave the left gain stale. Staging writes made while an update is pending must still reach the active path, and a sequencer that latched codes at arm time would miss them. A sweep over every code with extreme positive and negative samples exposes off-by-one errors in the shift/mantissa split, sign errors in rounding, and a mute that leaks the smallest non-zero gain.

// File: rtl/atten_pkg.sv
package atten_pkg;

    localparam int CODE_W  = 8;
    localparam int MANT_W  = 16;
    localparam int FRAC_W  = 15;
    localparam int SHIFT_W = 5;
    localparam int STEPS_PER_OCTAVE = 12;
    localparam logic [CODE_W-1:0] CODE_UNITY = '1;
    localparam logic [CODE_W-1:0] CODE_MUTE  = '0;

    typedef enum logic {
        ST_IDLE,
        ST_ARMED
    } upd_state_e;

    typedef struct packed {
        logic                mute;
        logic [MANT_W-1:0]   mant;
        logic [SHIFT_W-1:0]  shift;
    } gain_t;

    // 2^(-k/12) in Q1.15, rounded to nearest
    function automatic logic [MANT_W-1:0] semitone_mant(input logic [3:0] k);
        logic [MANT_W-1:0] m;
        unique case (k)
            4'd0:  m = 16'd32768;
            4'd1:  m = 16'd30929;
            4'd2:  m = 16'd29193;
            4'd3:  m = 16'd27554;
            4'd4:  m = 16'd26008;
            4'd5:  m = 16'd24548;
            4'd6:  m = 16'd23170;
            4'd7:  m = 16'd21870;
            4'd8:  m = 16'd20643;
            4'd9:  m = 16'd19484;
            4'd10: m = 16'd18390;
            4'd11: m = 16'd17358;
            default: m = 16'd0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/atten_regs.sv
module atten_regs
    import atten_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int NCH    = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [CODE_W:0]               wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [CODE_W:0]               rd_data,
    input  logic                          in_valid,
    output logic [NCH-1:0][CODE_W-1:0]    eff_code
);

    localparam int UPD_BIT = CODE_W;

    upd_state_e                   state_q, state_d;
    logic [NCH-1:0][CODE_W-1:0]   staged_q;
    logic [NCH-1:0][CODE_W-1:0]   active_q;
    logic [NCH-1:0]               hit;
    logic                         upd_req;
    logic                         apply;

    // address decode: one hit line per channel
    for (genvar c = 0; c < NCH; c++) begin : g_dec
        assign hit[c] = wr_en && (wr_addr == ADDR_W'(c));
    end

    assign upd_req = (|hit) && wr_data[UPD_BIT];

    // sequencer: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // sequencer: next state and apply output
    always_comb begin
        state_d = state_q;
        apply   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (upd_req) state_d = ST_ARMED;               // arm
            end
            ST_ARMED: begin
                if (in_valid) begin
                    apply   = 1'b1;                            // apply
                    state_d = upd_req ? ST_ARMED : ST_IDLE;    // rearm / back to idle
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // staging and active registers
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                staged_q[c] <= CODE_UNITY;
                active_q[c] <= CODE_UNITY;
            end else begin
                if (hit[c])  staged_q[c] <= wr_data[CODE_W-1:0];
                if (apply)   active_q[c] <= staged_q[c];
            end
        end
        assign eff_code[c] = apply ? staged_q[c] : active_q[c];

        // R6: active code only moves on an apply
        p_active_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !(in_valid && state_q == ST_ARMED) |=> $stable(active_q[c]));
        // R7: apply copies the staged value
        p_apply_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && state_q == ST_ARMED) |=> active_q[c] == $past(staged_q[c]));
        // R5: a write to this channel lands in its staging register
        p_stage_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
            hit[c] |=> staged_q[c] == $past(wr_data[CODE_W-1:0]));
    end

    // readback: update bit is never stored
    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NCH; c++) begin
            if (rd_addr == ADDR_W'(c)) rd_data = {1'b0, staged_q[c]};
        end
    end

    // R7: an update request always leaves the sequencer armed
    p_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_req |=> state_q == ST_ARMED);
    // R10: armed state persists until a sample arrives
    p_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && !in_valid) |=> state_q == ST_ARMED);

endmodule

// File: rtl/atten_gain.sv
module atten_gain
    import atten_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output gain_t             gain
);

    logic [CODE_W-1:0] depth;
    logic [CODE_W-1:0] octave;
    logic [CODE_W-1:0] step;

    always_comb begin
        depth      = CODE_UNITY - code;
        octave     = depth / CODE_W'(STEPS_PER_OCTAVE);
        step       = depth % CODE_W'(STEPS_PER_OCTAVE);
        gain.mute  = (code == CODE_MUTE);
        gain.mant  = semitone_mant(step[3:0]);
        gain.shift = octave[SHIFT_W-1:0];
    end

endmodule

// File: rtl/atten_scale.sv
module atten_scale
    import atten_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] smp_in,
    input  gain_t             gain,
    output logic              out_valid,
    output logic [DATA_W-1:0] smp_out
);

    localparam int PROD_W = DATA_W + MANT_W + 1;
    localparam int SHT_W  = SHIFT_W + 1;

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W:0]   rnd;
    logic signed [PROD_W:0]   sum;
    logic signed [PROD_W:0]   shifted;
    logic [SHT_W-1:0]         sh_total;
    logic [DATA_W-1:0]        scaled;

    always_comb begin
        prod     = $signed(smp_in) * $signed({1'b0, gain.mant});
        sh_total = SHT_W'(FRAC_W) + SHT_W'(gain.shift);
        rnd      = (PROD_W+1)'(1) <<< (sh_total - SHT_W'(1));
        sum      = $signed({prod[PROD_W-1], prod}) + rnd;
        shifted  = sum >>> sh_total;
        scaled   = gain.mute ? '0 : shifted[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            smp_out   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) smp_out <= scaled;
        end
    end

    // R9: output strobe trails the input strobe by one cycle
    p_valid_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(smp_out));
    // R2: muted gain gives zero
    p_mute_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && gain.mute) |=> smp_out == '0);
    // R3: unity gain passes the sample untouched
    p_unity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !gain.mute && gain.shift == '0 && gain.mant == MANT_W'(1 << FRAC_W))
        |=> smp_out == $past(smp_in));

endmodule

// File: rtl/stereo_atten.sv
module stereo_atten
    import atten_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CODE_W:0]   wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CODE_W:0]   rd_data,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right
);

    localparam int NCH = 2;

    logic [NCH-1:0][CODE_W-1:0] eff_code;
    logic [NCH-1:0][DATA_W-1:0] smp_in;
    logic [NCH-1:0][DATA_W-1:0] smp_out;
    logic [NCH-1:0]             ch_valid;
    gain_t                      gain [NCH];

    assign smp_in = {in_right, in_left};

    atten_regs #(.ADDR_W(ADDR_W), .NCH(NCH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .in_valid (in_valid),
        .eff_code (eff_code)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_path
        atten_gain u_gain (
            .code (eff_code[c]),
            .gain (gain[c])
        );
        atten_scale #(.DATA_W(DATA_W)) u_scale (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid),
            .smp_in    (smp_in[c]),
            .gain      (gain[c]),
            .out_valid (ch_valid[c]),
            .smp_out   (smp_out[c])
        );
    end

    assign out_valid = ch_valid[0];
    assign out_left  = smp_out[0];
    assign out_right = smp_out[1];

    // R1/R9: both channel strobes are always aligned
    p_pair_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid[0] == ch_valid[1]);

endmodule

// File: tb/sim_stereo_atten.sv
module sim_stereo_atten;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [8:0]  wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [8:0]  rd_data;
    logic        in_valid = 1'b0;
    logic [23:0] in_left = '0;
    logic [23:0] in_right = '0;
    logic        out_valid;
    logic [23:0] out_left;
    logic [23:0] out_right;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int stg [2];
    int act [2];
    bit pend;
    int exp_l, exp_r;
    bit exp_v;

    always #2 clk = ~clk;

    stereo_atten u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );

    function automatic int ref_scale(int s, int code);
        int d, sh, k, sft;
        longint m, p, r;
        if (code == 0) return 0;
        d  = 255 - code;
        sh = d / 12;
        k  = d % 12;
        m  = longint'($floor(32768.0 * (2.0 ** (-real'(k) / 12.0)) + 0.5));
        p  = longint'(s) * m;
        sft = 15 + sh;
        r  = (p + (64'sd1 <<< (sft - 1))) >>> sft;
        return int'(r);
    endfunction

    function automatic int sx24(logic [23:0] v);
        return int'($signed(v));
    endfunction

    task automatic check(string tag, int act_v, int exp_v2);
        checks++;
        if (act_v !== exp_v2) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v2);
        end
    endtask

    task automatic model_reset();
        stg[0] = 255; stg[1] = 255; act[0] = 255; act[1] = 255;
        pend = 0; exp_l = 0; exp_r = 0; exp_v = 0;
    endtask

    // one clock: drive at negedge, model, compare at next negedge
    task automatic cyc(bit we, int addr, int data, bit vin, int l, int r, int ra, string tag);
        int exp_rd;
        wr_en    = we;
        wr_addr  = 2'(addr);
        wr_data  = 9'(data);
        in_valid = vin;
        in_left  = 24'(l);
        in_right = 24'(r);
        rd_addr  = 2'(ra);
        if (vin) begin
            int gl, gr;
            gl = pend ? stg[0] : act[0];
            gr = pend ? stg[1] : act[1];
            exp_l = ref_scale(l, gl);
            exp_r = ref_scale(r, gr);
            exp_v = 1;
            if (pend) begin act[0] = stg[0]; act[1] = stg[1]; end
        end else begin
            exp_v = 0;
        end
        if (we && addr < 2) stg[addr] = data & 255;
        if (we && addr < 2 && data[8]) pend = 1;
        else if (vin) pend = 0;
        @(posedge clk);
        @(negedge clk);
        exp_rd = (ra < 2) ? stg[ra] : 0;
        check({tag, " valid"}, int'(out_valid), int'(exp_v));
        check({tag, " left"},  sx24(out_left),  exp_l);
        check({tag, " right"}, sx24(out_right), exp_r);
        check({tag, " R8 readback"}, int'(rd_data), exp_rd);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, i % 4, tag);
    endtask

    function automatic int rsmp();
        return int'($signed(24'($urandom)));
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 valid at reset", int'(out_valid), 0);
        check("R1 left at reset", sx24(out_left), 0);
        check("R1 readback at reset", int'(rd_data), 255);
        rst_n = 1'b1;
        idle(2, "R1");

        // R3: unity default, extremes
        cyc(0, 0, 0, 1, 8388607, -8388608, 0, "R3 unity");
        cyc(0, 0, 0, 1, -1, 1, 1, "R3 unity");
        cyc(0, 0, 0, 1, 12345, -54321, 0, "R3 unity");

        // R6: staging only
        cyc(1, 0, 'h080, 0, 0, 0, 0, "R6 stage left");
        cyc(1, 1, 'h040, 1, 4000000, -4000000, 1, "R6 stage right");
        cyc(0, 0, 0, 1, 4000000, -4000000, 0, "R6 no change");
        idle(3, "R9 hold");

        // R7: update via right address with same-cycle sample
        cyc(1, 1, 'h140, 1, 3000000, 3000000, 1, "R7 same-cycle old gain");
        cyc(0, 0, 0, 1, 3000000, 3000000, 0, "R7 both switch");
        cyc(0, 0, 0, 1, -3000000, 7, 1, "R7 after");

        // R10: long wait with staging writes in between
        cyc(1, 0, 'h1F0, 0, 0, 0, 0, "R10 arm");
        idle(20, "R10 wait");
        cyc(1, 1, 'h0A5, 0, 0, 0, 1, "R10 late stage");
        idle(5, "R10 wait");
        cyc(0, 0, 0, 1, 8388607, -8388608, 0, "R10 apply");

        // R2: mute
        cyc(1, 0, 'h000, 0, 0, 0, 0, "R2 stage");
        cyc(1, 1, 'h100, 0, 0, 0, 1, "R2 arm");
        cyc(0, 0, 0, 1, 8388607, -8388608, 0, "R2 mute");
        cyc(0, 0, 0, 1, 1, -1, 0, "R2 mute");

        // R5: unmapped addresses ignored
        cyc(1, 2, 'h1FF, 0, 0, 0, 2, "R5 addr2");
        cyc(1, 3, 'h155, 0, 0, 0, 3, "R5 addr3");
        cyc(0, 0, 0, 1, 100, 100, 0, "R5 still muted");

        // R4: sweep every code with extremes and random samples
        for (int c = 255; c >= 1; c--) begin
            cyc(1, 0, c, 0, 0, 0, 0, "R4 stage");
            cyc(1, 1, 'h100 | (256 - c), 0, 0, 0, 1, "R4 arm");
            cyc(0, 0, 0, 1, 8388607, -8388608, 0, "R4 extreme");
            cyc(0, 0, 0, 1, -8388608, 8388607, 1, "R4 extreme");
            cyc(0, 0, 0, 1, rsmp(), rsmp(), 0, "R4 random");
            cyc(0, 0, 0, 1, -(1 << (c % 23)), (1 << (c % 23)), 0, "R4 power");
        end

        // random mix of everything
        for (int i = 0; i < 4000; i++) begin
            bit we, vin;
            we  = ($urandom % 4) == 0;
            vin = ($urandom % 3) == 0;
            cyc(we, int'($urandom % 4), int'($urandom % 512), vin, rsmp(), rsmp(),
                int'($urandom % 4), "R10 random");
        end

        // R1: reset in the middle restores defaults
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        model_reset();
        rst_n = 1'b1;
        cyc(0, 0, 0, 1, 777, -777, 1, "R1 reset again");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule